// File: doc/BRIEF.md
# Audio Front-End Power Control Register with ADC Warm-Up Gate

This block holds the 8-bit power control word of a mixed-signal audio front end. A plain register bus writes and reads it. The block turns the stored bits into one power-enable line for each analog or digital section:

- left ADC channel
- right ADC channel
- shared ADC digital section
- microphone amplifier
- left input gain stage
- mono line output
- stereo line output
- mono beep input
- stereo beep input
- common reference voltage

The right ADC channel's power bit lives in another register. It arrives here as a separate input.

After an ADC channel is switched on, its converter needs a fixed number of sample periods to settle. The block counts sample-rate strobes from each rising edge of either ADC power bit. It holds an "ADC data valid" output low until the count is done. Clearing both ADC bits drops the valid output at once.

The enables drive the analog power switches directly. The valid output qualifies the ADC sample stream.

Top module: `pwr_ctl_reg`

## Requirements
- R1: When `wr_en` is high and `addr` equals 0x00 at a rising clock edge, the register takes `wdata` at that edge. `rdata` shows the stored word combinationally while `addr` is 0x00, and shows 0x00 for any other address.
- R2: A write strobe whose address is not 0x00 leaves the stored word unchanged.
- R3: After reset the stored word is 0x00, every enable output is 0 and `adc_valid` is 0.
- R4: The enables follow fixed bit positions of the word: bit 0 → `en_adc_l`, bit 3 → `en_mono_out`, bit 4 → `en_stereo_out`, bit 5 → `en_beep_mono`, bit 6 → `en_beep_stereo`, bit 7 → `en_vref`. `en_adc_r` follows input `adc_r_pwr`.
- R5: `en_adc_dig` is 1 when bit 0 or `adc_r_pwr` is 1, and 0 only when both are 0.
- R6: `en_mic_amp` follows bit 1 alone. `en_gain_l` is 1 when bit 1 or bit 2 is 1.
- R7: A 0→1 change of bit 0 or of `adc_r_pwr` starts a warm-up. The change becomes visible in the cycle after the edge that stores bit 0, or in the cycle `adc_r_pwr` rises. `fs_tick` samples on the next edge, including the one that ends that cycle, are not counted. `adc_valid` rises in the cycle after the edge that samples the 2081st counted `fs_tick`.
- R8: A new 0→1 change of either ADC bit restarts the count from zero, whether a warm-up is running or finished. `adc_valid` is 0 from the cycle the change is visible.
- R9: While bit 0 and `adc_r_pwr` are both 0, `adc_valid` is 0 in that same cycle and the count is cleared.
- R10: The warm-up count advances only on clock edges where `fs_tick` is 1.
- R11: Changing bits 5 or 6 alters only `en_beep_mono` and `en_beep_stereo`. All other outputs, including a running or finished warm-up, are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| adc_r_pwr | input | 1 | Right ADC power bit from another register |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| en_adc_l | output | 1 | Left ADC analog power |
| en_adc_r | output | 1 | Right ADC analog power |
| en_adc_dig | output | 1 | Shared ADC digital section power |
| en_mic_amp | output | 1 | Microphone amplifier power |
| en_gain_l | output | 1 | Left input gain stage power |
| en_mono_out | output | 1 | Mono line output power |
| en_stereo_out | output | 1 | Stereo line output power |
| en_beep_mono | output | 1 | Mono beep input power |
| en_beep_stereo | output | 1 | Stereo beep input power |
| en_vref | output | 1 | Common reference voltage power |
| adc_valid | output | 1 | ADC data valid after warm-up |

## Verification
The hardest situation to reach from the ports is a restart that arrives after a warm-up has already finished. The valid flag must fall in the very cycle the new rising edge appears, although the counter has not yet cleared.

The stimulus gets there in steps:
1. It completes a left-channel warm-up.
2. It drops and re-raises the right-channel input while the left bit stays on.
3. It also raises the right channel partway through a slow-strobe warm-up, to cover a restart while a count is running.

A cycle-accurate behavioural model is compared against every output on every clock. Off-by-one errors in the 2081-strobe count and in the moment the edge is seen therefore show up at once.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  localparam int unsigned BIT_ADC_L       = 0;
  localparam int unsigned BIT_MIC_L       = 1;
  localparam int unsigned BIT_GAIN_L      = 2;
  localparam int unsigned BIT_MONO_OUT    = 3;
  localparam int unsigned BIT_STEREO_OUT  = 4;
  localparam int unsigned BIT_BEEP_MONO   = 5;
  localparam int unsigned BIT_BEEP_STEREO = 6;
  localparam int unsigned BIT_VREF        = 7;

  typedef struct packed {
    logic vref;
    logic beep_stereo;
    logic beep_mono;
    logic stereo_out;
    logic mono_out;
    logic gain_l;
    logic mic_amp;
    logic adc_dig;
    logic adc_r;
    logic adc_l;
  } pwr_en_t;

  // Combine the stored word and the external right-ADC bit into enables.
  function automatic pwr_en_t decode_pwr(input logic [7:0] word, input logic adc_r);
    pwr_en_t e;
    e.adc_l       = word[BIT_ADC_L];
    e.adc_r       = adc_r;
    e.adc_dig     = word[BIT_ADC_L] | adc_r;
    e.mic_amp     = word[BIT_MIC_L];
    e.gain_l      = word[BIT_MIC_L] | word[BIT_GAIN_L];
    e.mono_out    = word[BIT_MONO_OUT];
    e.stereo_out  = word[BIT_STEREO_OUT];
    e.beep_mono   = word[BIT_BEEP_MONO];
    e.beep_stereo = word[BIT_BEEP_STEREO];
    e.vref        = word[BIT_VREF];
    return e;
  endfunction

  // Width needed to hold counts 0 .. cycles-1.
  function automatic int unsigned warm_cnt_width(input int unsigned cycles);
    return (cycles > 2) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/pwr_reg_bank.sv
module pwr_reg_bank #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_ADDR = 0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] word_q,
  output logic              wr_hit
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic addr_hit;

  assign addr_hit = (addr == MY_ADDR);
  assign wr_hit   = wr_en & addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_VAL;
    end else if (wr_hit) begin
      word_q <= wdata;
    end
  end

  assign rdata = addr_hit ? word_q : '0;

endmodule

// File: rtl/pwr_decoder.sv
module pwr_decoder
  import pwr_ctl_pkg::*;
(
  input  logic [7:0] word,
  input  logic       adc_r,
  output pwr_en_t    en
);

  always_comb begin
    en = decode_pwr(word, adc_r);
  end

endmodule

// File: rtl/adc_warmup.sv
module adc_warmup
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 2081,
  localparam int unsigned CNT_W = warm_cnt_width(INIT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_l,
  input  logic             pwr_r,
  input  logic             fs_tick,
  output logic             start_evt,
  output logic             any_on,
  output logic             last_tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q,
  output logic             data_valid
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(INIT_CYCLES - 1);

  logic prev_l_q;
  logic prev_r_q;

  assign start_evt = (pwr_l & ~prev_l_q) | (pwr_r & ~prev_r_q);
  assign any_on    = pwr_l | pwr_r;
  assign last_tick = fs_tick & ~done_q & (cnt_q == TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l_q <= 1'b0;
      prev_r_q <= 1'b0;
    end else begin
      prev_l_q <= pwr_l;
      prev_r_q <= pwr_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_evt || !any_on) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (fs_tick && !done_q) begin
      if (last_tick) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign data_valid = done_q & any_on & ~start_evt;

endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_ADDR    = 0,
  parameter int unsigned INIT_CYCLES = 2081
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              adc_r_pwr,
  input  logic              fs_tick,
  output logic              en_adc_l,
  output logic              en_adc_r,
  output logic              en_adc_dig,
  output logic              en_mic_amp,
  output logic              en_gain_l,
  output logic              en_mono_out,
  output logic              en_stereo_out,
  output logic              en_beep_mono,
  output logic              en_beep_stereo,
  output logic              en_vref,
  output logic              adc_valid
);

  localparam int unsigned CNT_W = warm_cnt_width(INIT_CYCLES);

  logic [7:0]       word_q;
  logic             wr_hit;
  pwr_en_t          en;
  logic             start_evt;
  logic             any_on;
  logic             last_tick;
  logic [CNT_W-1:0] warm_cnt;
  logic             warm_done;

  pwr_reg_bank #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (8),
    .REG_ADDR(REG_ADDR),
    .RST_VAL (8'h00)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .word_q(word_q),
    .wr_hit(wr_hit)
  );

  pwr_decoder u_dec (
    .word (word_q),
    .adc_r(adc_r_pwr),
    .en   (en)
  );

  adc_warmup #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_warm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_l     (word_q[BIT_ADC_L]),
    .pwr_r     (adc_r_pwr),
    .fs_tick   (fs_tick),
    .start_evt (start_evt),
    .any_on    (any_on),
    .last_tick (last_tick),
    .cnt_q     (warm_cnt),
    .done_q    (warm_done),
    .data_valid(adc_valid)
  );

  assign en_adc_l       = en.adc_l;
  assign en_adc_r       = en.adc_r;
  assign en_adc_dig     = en.adc_dig;
  assign en_mic_amp     = en.mic_amp;
  assign en_gain_l      = en.gain_l;
  assign en_mono_out    = en.mono_out;
  assign en_stereo_out  = en.stereo_out;
  assign en_beep_mono   = en.beep_mono;
  assign en_beep_stereo = en.beep_stereo;
  assign en_vref        = en.vref;

endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_ADDR    = 0,
  parameter int unsigned INIT_CYCLES = 2081,
  localparam int unsigned CNT_W = warm_cnt_width(INIT_CYCLES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        word_q,
  input logic              adc_r_pwr,
  input logic              fs_tick,
  input logic              start_evt,
  input logic              last_tick,
  input logic [CNT_W-1:0]  warm_cnt,
  input logic              warm_done,
  input logic              en_adc_dig,
  input logic              adc_valid
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [CNT_W-1:0]  TERM    = CNT_W'(INIT_CYCLES - 1);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MY_ADDR) |=> (word_q == $past(wdata))); // R1

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != MY_ADDR) |=> $stable(word_q)); // R2

  AST_DIG_FOLLOWS_EITHER: assert property (@(posedge clk) disable iff (!rst_n)
    en_adc_dig == (word_q[BIT_ADC_L] | adc_r_pwr)); // R5

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (warm_cnt == '0 && !warm_done)); // R8

  AST_VALID_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |-> (word_q[BIT_ADC_L] | adc_r_pwr)); // R9

  AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_tick && !start_evt && (word_q[BIT_ADC_L] | adc_r_pwr)) |=> $stable(warm_cnt)); // R10

  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_done) |-> $past(last_tick)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    warm_cnt <= TERM); // R7

endmodule

bind pwr_ctl_reg pwr_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .REG_ADDR   (REG_ADDR),
  .INIT_CYCLES(INIT_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .word_q    (word_q),
  .adc_r_pwr (adc_r_pwr),
  .fs_tick   (fs_tick),
  .start_evt (start_evt),
  .last_tick (last_tick),
  .warm_cnt  (warm_cnt),
  .warm_done (warm_done),
  .en_adc_dig(en_adc_dig),
  .adc_valid (adc_valid)
);

// File: tb/pwr_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module pwr_ctl_reg_tb_top;

  localparam int WARM = 2081;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       adc_r_pwr = 1'b0;
  logic       fs_tick = 1'b0;
  logic       en_adc_l, en_adc_r, en_adc_dig, en_mic_amp, en_gain_l;
  logic       en_mono_out, en_stereo_out, en_beep_mono, en_beep_stereo, en_vref;
  logic       adc_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_mode = 0;
  int tick_div  = 0;
  bit finished  = 0;

  always #4 clk = ~clk;

  pwr_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .adc_r_pwr(adc_r_pwr), .fs_tick(fs_tick),
    .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_adc_dig(en_adc_dig),
    .en_mic_amp(en_mic_amp), .en_gain_l(en_gain_l), .en_mono_out(en_mono_out),
    .en_stereo_out(en_stereo_out), .en_beep_mono(en_beep_mono),
    .en_beep_stereo(en_beep_stereo), .en_vref(en_vref), .adc_valid(adc_valid)
  );

  // Behavioural reference: stored word, last-seen ADC bits, strobe tally.
  int m_word = 0;
  int m_prev_l = 0;
  int m_prev_r = 0;
  int m_ticks = 0;
  int m_ready = 0;

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  function automatic int m_edge();
    return ((bitof(m_word, 0) == 1 && m_prev_l == 0) ||
            (adc_r_pwr == 1'b1 && m_prev_r == 0)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 0; m_prev_l = 0; m_prev_r = 0; m_ticks = 0; m_ready = 0;
    end else begin
      int powered;
      powered = bitof(m_word, 0) | int'(adc_r_pwr);
      if (m_edge() == 1 || powered == 0) begin
        m_ticks = 0; m_ready = 0;
      end else if (fs_tick && m_ready == 0) begin
        m_ticks++;
        if (m_ticks == WARM) begin m_ready = 1; m_ticks = 0; end
      end
      m_prev_l = bitof(m_word, 0);
      m_prev_r = int'(adc_r_pwr);
      if (wr_en && addr == 8'h00) m_word = int'(wdata);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output with the model, away from the clock edges.
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      int pw;
      pw = bitof(m_word, 0) | int'(adc_r_pwr);
      chk("R1", "rdata", int'(rdata), (addr == 8'h00) ? m_word : 0);
      chk("R4", "en_adc_l", int'(en_adc_l), bitof(m_word, 0));
      chk("R4", "en_adc_r", int'(en_adc_r), int'(adc_r_pwr));
      chk("R5", "en_adc_dig", int'(en_adc_dig), pw);
      chk("R6", "en_mic_amp", int'(en_mic_amp), bitof(m_word, 1));
      chk("R6", "en_gain_l", int'(en_gain_l), bitof(m_word, 1) | bitof(m_word, 2));
      chk("R4", "en_mono_out", int'(en_mono_out), bitof(m_word, 3));
      chk("R4", "en_stereo_out", int'(en_stereo_out), bitof(m_word, 4));
      chk("R11", "en_beep_mono", int'(en_beep_mono), bitof(m_word, 5));
      chk("R11", "en_beep_stereo", int'(en_beep_stereo), bitof(m_word, 6));
      chk("R4", "en_vref", int'(en_vref), bitof(m_word, 7));
      chk("R7", "adc_valid", int'(adc_valid),
          (m_ready == 1 && pw == 1 && m_edge() == 0) ? 1 : 0);
    end
  end

  // Sample-rate strobe generator: 0 none, 1 every cycle, 2 every other cycle.
  always @(negedge clk) begin
    tick_div <= tick_div + 1;
    case (tick_mode)
      1: fs_tick <= 1'b1;
      2: fs_tick <= tick_div[0];
      default: fs_tick <= 1'b0;
    endcase
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle(3);
    #2;
    // R3: reset state at the ports
    chk("R3", "rdata in reset", int'(rdata), 0);
    chk("R3", "enables in reset",
        int'({en_adc_l, en_adc_r, en_adc_dig, en_mic_amp, en_gain_l, en_mono_out,
              en_stereo_out, en_beep_mono, en_beep_stereo, en_vref}), 0);
    chk("R3", "adc_valid in reset", int'(adc_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2: foreign addresses ignored, read 0 while addressed
    reg_wr(8'h05, 8'hFF);
    reg_wr(8'h80, 8'hA5);
    @(negedge clk); addr = 8'h05; @(negedge clk); addr = 8'h00;
    idle(2);

    // R4 / R6: walk each bit and the gain-stage combinations
    for (int i = 1; i < 8; i++) begin
      reg_wr(8'h00, 8'(1 << i));
      idle(2);
    end
    reg_wr(8'h00, 8'h06);
    idle(2);
    reg_wr(8'h00, 8'h00);
    idle(2);

    // R5 / R7 / R9: right channel only, strobe every cycle
    tick_mode = 1;
    @(negedge clk); adc_r_pwr = 1'b1;
    idle(WARM + 20);
    @(negedge clk); adc_r_pwr = 1'b0;
    idle(10);

    // R8: restart during a slow warm-up
    tick_mode = 2;
    reg_wr(8'h00, 8'h01);
    idle(1500);
    @(negedge clk); adc_r_pwr = 1'b1;
    idle(2 * WARM + 40);

    // R11: beep bits while warm-up finished
    reg_wr(8'h00, 8'h61);
    idle(5);
    reg_wr(8'h00, 8'h01);
    idle(5);

    // R8: restart after completion, left bit held on
    @(negedge clk); adc_r_pwr = 1'b0;
    idle(3);
    @(negedge clk); adc_r_pwr = 1'b1;
    idle(2 * WARM + 40);

    // R9: drop both bits together
    @(negedge clk); adc_r_pwr = 1'b0;
    reg_wr(8'h00, 8'h00);
    idle(5);

    // R10: no strobes, so no progress
    tick_mode = 0;
    reg_wr(8'h00, 8'h01);
    idle(3000);
    #2;
    chk("R10", "adc_valid without strobes", int'(adc_valid), 0);
    reg_wr(8'h00, 8'h00);
    idle(4);

    finished = 1;
    summary();
  end

endmodule